// File: doc/BRIEF.md
# Dimension-Order Mesh Route Selector

This block computes the route for one input port of a two-dimensional mesh router. Each arriving header carries a signed relative offset (dx, dy), which is the destination coordinate minus the current coordinate in each dimension. The selector picks one of five outputs: west, east, south, north, or the local processor. The x offset is always cleared before any y hop. A route is therefore one run along x, a single turn, and one run along y. Because of this ordering the routing cannot deadlock.

Before the header leaves, the selector moves the offset of the dimension being travelled one step toward zero. The next switch then sees only the hops that are left. Headers enter through a valid/ready handshake, one per cycle. The result leaves through a single registered stage, and that stage holds its contents while the downstream side is not ready. The payload passes through the block unchanged.

Top module: `dor_route_select`

## Requirements
- R1: When dx < 0, the west output is chosen (out_port bit 0). out_dx equals dx + 1 and out_dy equals dy.
- R2: When dx > 0, the east output is chosen (out_port bit 1). out_dx equals dx − 1 and out_dy equals dy.
- R3: When dx = 0 and dy < 0, the south output is chosen (out_port bit 2). out_dy equals dy + 1 and out_dx stays 0.
- R4: When dx = 0 and dy > 0, the north output is chosen (out_port bit 3). out_dy equals dy − 1 and out_dx stays 0.
- R5: When dx = 0 and dy = 0, the local processor output is chosen (out_port bit 4), and both output offsets are 0.
- R6: While out_valid is high, out_port has exactly one bit set. While out_valid is low, out_port is all zeros.
- R7: While out_valid is high and out_ready is low, every output holds its value into the next cycle.
- R8: in_ready equals (not out_valid) or out_ready. A header accepted on one clock edge appears on the outputs after that edge, and out_valid stays high until the header is consumed.
- R9: After a synchronous active-high reset, out_valid is low, out_port is zero and in_ready is high.
- R10: out_payload equals the payload that was accepted with the header, unchanged, and headers leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming header is present |
| in_ready | output | 1 | Selector can take a header this cycle |
| in_dx | input | OFS_W | Signed remaining x offset |
| in_dy | input | OFS_W | Signed remaining y offset |
| in_payload | input | PAY_W | Data carried alongside the header |
| out_valid | output | 1 | Routed header is present |
| out_ready | input | 1 | Downstream takes the routed header |
| out_port | output | 5 | One-hot output choice: west, east, south, north, local (bits 0 to 4) |
| out_dx | output | OFS_W | x offset after this hop |
| out_dy | output | OFS_W | y offset after this hop |
| out_payload | output | PAY_W | Unchanged payload |

## Verification
The hardest case to reach from the ports is a held result while the upstream side keeps offering a different header. That case exercises both the hold requirement and the ordering requirement, and it only arises when back-pressure lasts for several cycles. The stimulus therefore drops out_ready in random bursts while in_valid stays mostly high, and checks each held cycle against the previous one. Directed headers cover the extreme offsets (most negative and most positive in each dimension), single-step offsets and the all-zero header. Random headers set each offset to zero with raised probability, so the south, north and local choices occur often.

// File: rtl/dor_pkg.sv
package dor_pkg;

    localparam int NPORT = 5;

    // Output port index; the bit position in the one-hot vector equals the value.
    typedef enum logic [2:0] {
        P_WEST  = 3'd0,
        P_EAST  = 3'd1,
        P_SOUTH = 3'd2,
        P_NORTH = 3'd3,
        P_LOCAL = 3'd4
    } port_e;

    function automatic logic [NPORT-1:0] port_onehot(input port_e p);
        logic [NPORT-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dor_port_decide.sv
module dor_port_decide
    import dor_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic signed [OFS_W-1:0] dx,
    input  logic signed [OFS_W-1:0] dy,
    output port_e                   sel
);
    logic x_zero;
    logic y_zero;
    logic x_neg;
    logic y_neg;

    assign x_zero = (dx == '0);
    assign y_zero = (dy == '0);
    assign x_neg  = dx[OFS_W-1];
    assign y_neg  = dy[OFS_W-1];

    // x is settled completely before any y movement
    always_comb begin
        if (!x_zero)      sel = x_neg ? P_WEST : P_EAST;
        else if (!y_zero) sel = y_neg ? P_SOUTH : P_NORTH;
        else              sel = P_LOCAL;
    end
endmodule

// File: rtl/dor_offset_step.sv
module dor_offset_step
    import dor_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic signed [OFS_W-1:0] dx,
    input  logic signed [OFS_W-1:0] dy,
    input  port_e                   sel,
    output logic signed [OFS_W-1:0] nx,
    output logic signed [OFS_W-1:0] ny
);
    localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

    always_comb begin
        nx = dx;
        ny = dy;
        unique case (sel)
            P_WEST:  nx = dx + ONE;
            P_EAST:  nx = dx - ONE;
            P_SOUTH: ny = dy + ONE;
            P_NORTH: ny = dy - ONE;
            default: ;
        endcase
    end
endmodule

// File: rtl/dor_out_stage.sv
module dor_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);
    logic          vld_q;
    logic [DW-1:0] dat_q;

    assign up_ready = !vld_q || dn_ready;
    assign dn_valid = vld_q;
    assign dn_data  = dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (up_ready) begin
            vld_q <= up_valid;
            if (up_valid) dat_q <= up_data;
        end
    end
endmodule

// File: rtl/dor_route_select.sv
module dor_route_select
    import dor_pkg::*;
#(
    parameter int OFS_W = 6,
    parameter int PAY_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [OFS_W-1:0] in_dx,
    input  logic signed [OFS_W-1:0] in_dy,
    input  logic [PAY_W-1:0]        in_payload,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [NPORT-1:0]        out_port,
    output logic signed [OFS_W-1:0] out_dx,
    output logic signed [OFS_W-1:0] out_dy,
    output logic [PAY_W-1:0]        out_payload
);
    localparam int DW = NPORT + 2 * OFS_W + PAY_W;

    typedef struct packed {
        logic [NPORT-1:0]        port;
        logic signed [OFS_W-1:0] dx;
        logic signed [OFS_W-1:0] dy;
        logic [PAY_W-1:0]        pay;
    } route_t;

    port_e                   sel;
    logic signed [OFS_W-1:0] nx;
    logic signed [OFS_W-1:0] ny;
    route_t                  nxt;
    route_t                  cur;
    logic [DW-1:0]           cur_bits;

    dor_port_decide #(.OFS_W(OFS_W)) u_decide (
        .dx (in_dx),
        .dy (in_dy),
        .sel(sel)
    );

    dor_offset_step #(.OFS_W(OFS_W)) u_step (
        .dx (in_dx),
        .dy (in_dy),
        .sel(sel),
        .nx (nx),
        .ny (ny)
    );

    always_comb begin
        nxt.port = port_onehot(sel);
        nxt.dx   = nx;
        nxt.dy   = ny;
        nxt.pay  = in_payload;
    end

    dor_out_stage #(.DW(DW)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .up_valid(in_valid),
        .up_ready(in_ready),
        .up_data (nxt),
        .dn_valid(out_valid),
        .dn_ready(out_ready),
        .dn_data (cur_bits)
    );

    assign cur         = route_t'(cur_bits);
    assign out_port    = out_valid ? cur.port : '0;
    assign out_dx      = cur.dx;
    assign out_dy      = cur.dy;
    assign out_payload = cur.pay;
endmodule

// File: rtl/dor_route_select_chk.sv
module dor_route_select_chk #(
    parameter int OFS_W = 6,
    parameter int PAY_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic signed [OFS_W-1:0] in_dx,
    input logic signed [OFS_W-1:0] in_dy,
    input logic [PAY_W-1:0]        in_payload,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [4:0]              out_port,
    input logic signed [OFS_W-1:0] out_dx,
    input logic signed [OFS_W-1:0] out_dy,
    input logic [PAY_W-1:0]        out_payload
);
    localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);
    logic acc;
    assign acc = in_valid && in_ready;

    assert_west_R1: assert property (@(posedge clk) disable iff (rst)
        (acc && in_dx < 0) |=> (out_port == 5'b00001 && out_dx == $past(in_dx) + ONE
                                && out_dy == $past(in_dy)));

    assert_east_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && in_dx > 0) |=> (out_port == 5'b00010 && out_dx == $past(in_dx) - ONE
                                && out_dy == $past(in_dy)));

    assert_south_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && in_dx == 0 && in_dy < 0) |=> (out_port == 5'b00100 && out_dx == 0
                                && out_dy == $past(in_dy) + ONE));

    assert_north_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && in_dx == 0 && in_dy > 0) |=> (out_port == 5'b01000 && out_dx == 0
                                && out_dy == $past(in_dy) - ONE));

    assert_local_R5: assert property (@(posedge clk) disable iff (rst)
        out_port[4] |-> (out_dx == 0 && out_dy == 0));

    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid ? $onehot(out_port) : (out_port == 5'b0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_dx)
                                && $stable(out_dy) && $stable(out_payload)));

    assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
        in_ready == (!out_valid || out_ready));

    assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    assert_payload_R10: assert property (@(posedge clk) disable iff (rst)
        acc |=> (out_payload == $past(in_payload)));
endmodule

bind dor_route_select dor_route_select_chk #(.OFS_W(OFS_W), .PAY_W(PAY_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_dx      (in_dx),
    .in_dy      (in_dy),
    .in_payload (in_payload),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_port   (out_port),
    .out_dx     (out_dx),
    .out_dy     (out_dy),
    .out_payload(out_payload)
);

// File: tb/dor_route_select_bench.sv
module dor_route_select_bench;
    localparam int W  = 6;
    localparam int P  = 16;
    localparam int EW = 5 + 2 * W + P;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic signed [W-1:0] in_dx = '0;
    logic signed [W-1:0] in_dy = '0;
    logic [P-1:0]        in_payload = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [4:0]          out_port;
    logic signed [W-1:0] out_dx;
    logic signed [W-1:0] out_dy;
    logic [P-1:0]        out_payload;

    int checks = 0;
    int fails  = 0;
    logic [EW-1:0] expq[$];

    always #5 clk = ~clk;

    dor_route_select #(.OFS_W(W), .PAY_W(P)) u_dor_route_select (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dx(in_dx), .in_dy(in_dy), .in_payload(in_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
        .out_dx(out_dx), .out_dy(out_dy), .out_payload(out_payload)
    );

    function automatic logic [EW-1:0] model(input logic signed [W-1:0] dx,
                                            input logic signed [W-1:0] dy,
                                            input logic [P-1:0] pay);
        logic [4:0] pt;
        logic signed [W-1:0] ex;
        logic signed [W-1:0] ey;
        ex = dx; ey = dy;
        if (dx < 0)      begin pt = 5'b00001; ex = dx + W'(1); end
        else if (dx > 0) begin pt = 5'b00010; ex = dx - W'(1); end
        else if (dy < 0) begin pt = 5'b00100; ey = dy + W'(1); end
        else if (dy > 0) begin pt = 5'b01000; ey = dy - W'(1); end
        else               pt = 5'b10000;
        return {pt, ex, ey, pay};
    endfunction

    function automatic string req_of(input logic [4:0] pt);
        case (pt)
            5'b00001: return "R1";
            5'b00010: return "R2";
            5'b00100: return "R3";
            5'b01000: return "R4";
            default:  return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [EW-1:0] prev_out;
    logic          prev_stall = 1'b0;
    int            dir_idx = 0;
    logic signed [W-1:0] dir_x [9];
    logic signed [W-1:0] dir_y [9];

    // one cycle: sample at negedge, compare, then drive new inputs
    task automatic step(input bit use_dir);
        logic [EW-1:0] now;
        @(negedge clk);
        now = {out_port, out_dx, out_dy, out_payload};
        if (prev_stall) check("R7", {63'd0, out_valid} | (now != prev_out ? 64'h2 : 64'h0), 64'h1);
        check("R8", {63'd0, out_valid}, {63'd0, expq.size() != 0});
        if (out_valid && expq.size() != 0) begin
            check(req_of(expq[0][EW-1 -: 5]), {32'd0, now}, {32'd0, expq[0]});
            check("R10", {48'd0, out_payload}, {48'd0, expq[0][P-1:0]});
        end
        if (!out_valid) check("R6", {59'd0, out_port}, 64'd0);
        else            check("R6", {63'd0, $countones(out_port) == 1}, 64'd1);
        out_ready = ($urandom % 4) != 0 || ($urandom % 2 == 0 && !use_dir);
        if (($urandom % 16) < 3) out_ready = 1'b0;
        prev_stall = out_valid && !out_ready;
        prev_out = now;
        if (out_valid && out_ready) void'(expq.pop_front());
        if (use_dir) begin
            in_valid = 1'b1;
            in_dx = dir_x[dir_idx % 9];
            in_dy = dir_y[dir_idx % 9];
        end else begin
            in_valid = ($urandom % 5) != 0;
            in_dx = ($urandom % 3 == 0) ? '0 : W'($urandom);
            in_dy = ($urandom % 3 == 0) ? '0 : W'($urandom);
        end
        in_payload = P'($urandom);
        #1;
        check("R8", {63'd0, in_ready}, {63'd0, !out_valid || out_ready});
        if (in_valid && in_ready) begin
            expq.push_back(model(in_dx, in_dy, in_payload));
            if (use_dir) dir_idx++;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        dir_x = '{6'sd0, 6'sd0, 6'sd0, 6'sd1, -6'sd1, -6'sd32, 6'sd31, 6'sd0, 6'sd0};
        dir_y = '{6'sd0, 6'sd1, -6'sd1, 6'sd0, 6'sd0, 6'sd31, -6'sd32, -6'sd32, 6'sd31};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9", {61'd0, out_valid, in_ready, out_port != 0}, {61'd0, 3'b010});
        while (dir_idx < 9) step(1'b1);
        for (int i = 0; i < 3000; i++) step(1'b0);
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (out_valid) void'(expq.pop_front());
        end
        check("R8", {63'd0, out_valid}, 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule